// File: doc/BRIEF.md
# Indexed Configuration RAM with Range Checksum

This block is a small battery-backed configuration store that a host reaches through two byte-wide ports. A write to the index port picks a location with its low seven bits. The top bit of the same write is kept as a mask for the non-maskable interrupt. Data-port reads and writes then act on the picked location. The store is 128 bytes by default. A 64-byte build drops the top address bit, so the upper half folds onto the lower half.

The lowest fourteen locations are not stored here. They form a window to an external timekeeping core: reads return that core's data, and writes are forwarded to it, except writes to the two read-only status locations at the top of the window. Above the window, plain RAM holds configuration bytes.

A scan engine, started by a one-cycle pulse, adds up the configuration bytes one per cycle into a 16-bit sum. It then compares the sum with a checksum word stored high byte first. It raises a one-cycle done strobe and a match flag.

Top module: `cfg_ram_port`

## Requirements
- R1: After reset the index is 0, the NMI mask output is 0, and the scan busy, done and match outputs are 0.
- R2: An index write stores bits 6:0 as the address and bit 7 as the NMI mask (1 = masked). Both hold until the next index write, and bit 7 never affects which location is addressed.
- R3: A data-port write to an address from 0Eh upward stores the byte. A data-port read returns, in the same cycle, the byte at the current address.
- R4: For addresses 00h-0Dh, the read data is the timekeeping core's return byte and the clock address output carries address bits 3:0. Data-port writes to 00h-0Bh raise the clock write enable together with the written byte.
- R5: Data-port writes to 0Ch and 0Dh are dropped: the clock write enable stays low.
- R6: With RAM_BYTES = 64, an index in 40h-7Fh addresses the same location as that index minus 40h, including the clock window.
- R7: The scan result is the 16-bit sum, modulo 65536, of bytes 10h through 2Dh. Bytes outside that range, such as 0Fh, 30h and 31h, do not change it.
- R8: The stored checksum word has its high byte at 2Eh and its low byte at 2Fh. The match flag is 1 exactly when that word equals the sum, and it is updated together with done.
- R9: A start pulse sampled while idle raises busy on the next cycle. Done is high for exactly one cycle, 31 clock edges after the edge that sampled start. A start pulse seen while busy is ignored.
- R10: A data-port write that lands during a scan, on a byte the scan has not yet reached, is included in the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Index port write strobe |
| idx_wdata_i | input | 8 | Index byte: 6:0 address, 7 NMI mask |
| dat_we_i | input | 1 | Data port write strobe |
| dat_wdata_i | input | 8 | Data port write byte |
| dat_rdata_o | output | 8 | Data port read byte for current address |
| nmi_mask_o | output | 1 | NMI mask, 1 = masked |
| rtc_addr_o | output | 4 | Address into the timekeeping core |
| rtc_we_o | output | 1 | Write enable to the timekeeping core |
| rtc_wdata_o | output | 8 | Write byte to the timekeeping core |
| rtc_rdata_i | input | 8 | Read byte from the timekeeping core |
| scan_start_i | input | 1 | Checksum scan start pulse |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | One-cycle end-of-scan strobe |
| sum_ok_o | output | 1 | Computed sum equals stored word |
| sum_o | output | SUM_W | Last computed sum |

## Verification
The scan engine reads the RAM through its own port, so a host data-port write can land in the same cycle as a scan step. The bench points the index at 2Ah, starts a scan, and writes a new byte there a few cycles later, before the scan reaches 2Ah. The reported sum must equal the sum of the model bytes that include the new value. A second start pulse in the middle of a scan must leave the done timing unchanged at 31 edges.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;
  localparam int IDX_W        = 7;
  localparam int DATA_W       = 8;
  localparam int RTC_LAST     = 13;  // 0Dh: top of clock window
  localparam int RTC_RO_FIRST = 12;  // 0Ch: first read-only clock byte
  localparam int SUM_FIRST    = 16;  // 10h
  localparam int SUM_LAST     = 45;  // 2Dh
  localparam int SUM_HI       = 46;  // 2Eh
  localparam int SUM_LO       = 47;  // 2Fh

  typedef enum logic [1:0] {
    SCAN_IDLE,
    SCAN_RUN,
    SCAN_CMP
  } scan_st_e;
endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
  import cfg_ram_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [AW-1:0]     addr_o,
  output logic              nmi_mask_o
);
  logic [IDX_W-1:0] idx_q;
  logic             nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      nmi_q <= 1'b0;
    end else if (we_i) begin
      idx_q <= wdata_i[IDX_W-1:0];
      nmi_q <= wdata_i[DATA_W-1];
    end
  end

  // narrower build drops upper index bits -> aliasing
  assign addr_o     = idx_q[AW-1:0];
  assign nmi_mask_o = nmi_q;

  // R2
  nmi_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (nmi_mask_o == $past(wdata_i[DATA_W-1])));
  // R2
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(addr_o) && $stable(nmi_mask_o)));
endmodule

// File: rtl/cfg_ram_array.sv
module cfg_ram_array
  import cfg_ram_pkg::*;
#(
  parameter int AW    = 7,
  parameter int DEPTH = 2 ** AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [AW-1:0]     scan_addr_i,
  output logic [DATA_W-1:0] scan_data_o,
  output logic [DATA_W-1:0] sum_hi_o,
  output logic [DATA_W-1:0] sum_lo_o
);
  localparam logic [AW-1:0] HI_A = AW'(SUM_HI);
  localparam logic [AW-1:0] LO_A = AW'(SUM_LO);

  logic [DATA_W-1:0] mem [DEPTH];

  // battery-backed store: no reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o     = mem[addr_i];
  assign scan_data_o = mem[scan_addr_i];
  assign sum_hi_o    = mem[HI_A];
  assign sum_lo_o    = mem[LO_A];
endmodule

// File: rtl/cfg_sum_scan.sv
module cfg_sum_scan
  import cfg_ram_pkg::*;
#(
  parameter int AW    = 7,
  parameter int SUM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic [AW-1:0]     addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [SUM_W-1:0]  sum_o
);
  localparam logic [AW-1:0] FIRST_A = AW'(SUM_FIRST);
  localparam logic [AW-1:0] LAST_A  = AW'(SUM_LAST);

  scan_st_e         st_q;
  logic [AW-1:0]    ptr_q;
  logic [SUM_W-1:0] acc_q, sum_q;
  logic             done_q, ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SCAN_IDLE;
      ptr_q  <= '0;
      acc_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SCAN_IDLE: begin
          if (start_i) begin
            st_q  <= SCAN_RUN;
            ptr_q <= FIRST_A;
            acc_q <= '0;
          end
        end
        SCAN_RUN: begin
          acc_q <= acc_q + SUM_W'(byte_i);
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == LAST_A) st_q <= SCAN_CMP;
        end
        SCAN_CMP: begin
          done_q <= 1'b1;
          sum_q  <= acc_q;
          ok_q   <= (acc_q == SUM_W'({hi_i, lo_i}));
          st_q   <= SCAN_IDLE;
        end
        default: st_q <= SCAN_IDLE;
      endcase
    end
  end

  assign addr_o = ptr_q;
  assign busy_o = (st_q != SCAN_IDLE);
  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign sum_o  = sum_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (addr_o >= FIRST_A && addr_o <= LAST_A + 1'b1));
endmodule

// File: rtl/cfg_ram_port.sv
module cfg_ram_port
  import cfg_ram_pkg::*;
#(
  parameter int RAM_BYTES = 128,
  parameter int SUM_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic [7:0]       idx_wdata_i,
  input  logic             dat_we_i,
  input  logic [7:0]       dat_wdata_i,
  output logic [7:0]       dat_rdata_o,
  output logic             nmi_mask_o,
  output logic [3:0]       rtc_addr_o,
  output logic             rtc_we_o,
  output logic [7:0]       rtc_wdata_o,
  input  logic [7:0]       rtc_rdata_i,
  input  logic             scan_start_i,
  output logic             scan_busy_o,
  output logic             scan_done_o,
  output logic             sum_ok_o,
  output logic [SUM_W-1:0] sum_o
);
  localparam int AW = $clog2(RAM_BYTES);
  localparam logic [AW-1:0] RTC_LAST_A = AW'(RTC_LAST);
  localparam logic [AW-1:0] RTC_RO_A   = AW'(RTC_RO_FIRST);

  logic [AW-1:0]     addr;
  logic [AW-1:0]     scan_addr;
  logic [DATA_W-1:0] ram_rdata, scan_byte, sum_hi, sum_lo;
  logic              in_rtc, rtc_ro, ram_we;

  cfg_index_reg #(.AW(AW)) u_index (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (idx_we_i),
    .wdata_i    (idx_wdata_i),
    .addr_o     (addr),
    .nmi_mask_o (nmi_mask_o)
  );

  assign in_rtc = (addr <= RTC_LAST_A);
  assign rtc_ro = in_rtc && (addr >= RTC_RO_A);
  assign ram_we = dat_we_i && !in_rtc;

  cfg_ram_array #(.AW(AW)) u_ram (
    .clk_i       (clk_i),
    .we_i        (ram_we),
    .addr_i      (addr),
    .wdata_i     (dat_wdata_i),
    .rdata_o     (ram_rdata),
    .scan_addr_i (scan_addr),
    .scan_data_o (scan_byte),
    .sum_hi_o    (sum_hi),
    .sum_lo_o    (sum_lo)
  );

  cfg_sum_scan #(.AW(AW), .SUM_W(SUM_W)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (scan_start_i),
    .byte_i  (scan_byte),
    .hi_i    (sum_hi),
    .lo_i    (sum_lo),
    .addr_o  (scan_addr),
    .busy_o  (scan_busy_o),
    .done_o  (scan_done_o),
    .ok_o    (sum_ok_o),
    .sum_o   (sum_o)
  );

  assign rtc_addr_o  = addr[3:0];
  assign rtc_we_o    = dat_we_i && in_rtc && !rtc_ro;
  assign rtc_wdata_o = dat_wdata_i;
  assign dat_rdata_o = in_rtc ? rtc_rdata_i : ram_rdata;

  // R5
  rtc_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_we_o |-> (rtc_addr_o < 4'd12));
  // R4
  rtc_wdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_we_o |-> (dat_we_i && rtc_wdata_o == dat_wdata_i));
endmodule

// File: tb/tb_cfg_ram_port.sv
module tb_cfg_ram_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0, dat_we = 1'b0, start = 1'b0;
  logic [7:0]  idx_wd = '0, dat_wd = '0, rtc_rd = '0;
  logic [7:0]  rdata, rtc_wdata;
  logic [3:0]  rtc_addr;
  logic        nmi, rtc_we, busy, done, ok;
  logic [15:0] sum;

  logic        s_idx_we = 1'b0, s_dat_we = 1'b0;
  logic [7:0]  s_idx_wd = '0, s_dat_wd = '0;
  logic [7:0]  s_rdata, s_rtc_wdata;
  logic [3:0]  s_rtc_addr;
  logic        s_nmi, s_rtc_we, s_busy, s_done, s_ok;
  logic [15:0] s_sum;

  logic [7:0]  model [128];
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  cfg_ram_port dut (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .idx_wdata_i(idx_wd),
    .dat_we_i(dat_we), .dat_wdata_i(dat_wd), .dat_rdata_o(rdata),
    .nmi_mask_o(nmi), .rtc_addr_o(rtc_addr), .rtc_we_o(rtc_we),
    .rtc_wdata_o(rtc_wdata), .rtc_rdata_i(rtc_rd), .scan_start_i(start),
    .scan_busy_o(busy), .scan_done_o(done), .sum_ok_o(ok), .sum_o(sum)
  );

  cfg_ram_port #(.RAM_BYTES(64)) dut64 (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(s_idx_we), .idx_wdata_i(s_idx_wd),
    .dat_we_i(s_dat_we), .dat_wdata_i(s_dat_wd), .dat_rdata_o(s_rdata),
    .nmi_mask_o(s_nmi), .rtc_addr_o(s_rtc_addr), .rtc_we_o(s_rtc_we),
    .rtc_wdata_o(s_rtc_wdata), .rtc_rdata_i(8'hC3), .scan_start_i(1'b0),
    .scan_busy_o(s_busy), .scan_done_o(s_done), .sum_ok_o(s_ok), .sum_o(s_sum)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; idx_wd = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    set_idx(a);
    dat_we = 1'b1; dat_wd = d;
    @(negedge clk); dat_we = 1'b0;
    if (a[6:0] > 7'h0D) model[a[6:0]] = d;
  endtask

  task automatic get(input logic [7:0] a, output logic [7:0] d);
    set_idx(a);
    #1 d = rdata;
  endtask

  function automatic logic [15:0] exp_sum();
    logic [15:0] s = '0;
    for (int i = 16; i <= 45; i++) s = s + 16'(model[i]);
    return s;
  endfunction

  function automatic logic exp_ok();
    return {model[46], model[47]} == exp_sum();
  endfunction

  task automatic run_scan(output int n);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 nmi", nmi, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ok", ok, 0);
    chk("R1 index", rtc_addr, 0);
  endtask

  task automatic t_index();
    logic [7:0] d;
    set_idx(8'h95);
    chk("R2 nmi set", nmi, 1);
    put(8'h9A, 8'h3C);
    chk("R2 nmi held", nmi, 1);
    get(8'h1A, d);
    chk("R2 bit7 not address", d, 8'h3C);
    chk("R2 nmi clear", nmi, 0);
  endtask

  task automatic t_ram();
    logic [7:0] d;
    put(8'h0E, 8'h11); put(8'h40, 8'h22); put(8'h7F, 8'h33);
    get(8'h0E, d); chk("R3 0E", d, 8'h11);
    get(8'h40, d); chk("R3 40", d, 8'h22);
    get(8'h7F, d); chk("R3 7F", d, 8'h33);
  endtask

  task automatic t_rtc();
    logic [7:0] d;
    rtc_rd = 8'h5A;
    get(8'h07, d);
    chk("R4 read", d, 8'h5A);
    chk("R4 addr", rtc_addr, 4'h7);
    set_idx(8'h03);
    dat_we = 1'b1; dat_wd = 8'h77;
    #1;
    chk("R4 we", rtc_we, 1);
    chk("R4 wdata", rtc_wdata, 8'h77);
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic t_rtc_ro();
    set_idx(8'h0C);
    dat_we = 1'b1; dat_wd = 8'hFF; #1;
    chk("R5 0C dropped", rtc_we, 0);
    @(negedge clk); dat_we = 1'b0;
    set_idx(8'h8D);
    dat_we = 1'b1; dat_wd = 8'hFF; #1;
    chk("R5 0D dropped", rtc_we, 0);
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic t_alias();
    @(negedge clk); s_idx_we = 1'b1; s_idx_wd = 8'h52;
    @(negedge clk); s_idx_we = 1'b0; s_dat_we = 1'b1; s_dat_wd = 8'hA5;
    @(negedge clk); s_dat_we = 1'b0; s_idx_we = 1'b1; s_idx_wd = 8'h12;
    @(negedge clk); s_idx_we = 1'b0; #1;
    chk("R6 52 aliases 12", s_rdata, 8'hA5);
    @(negedge clk); s_idx_we = 1'b1; s_idx_wd = 8'h45;
    @(negedge clk); s_idx_we = 1'b0; #1;
    chk("R6 45 clock addr", s_rtc_addr, 4'h5);
    chk("R6 45 clock data", s_rdata, 8'hC3);
  endtask

  task automatic t_sum_good();
    int n;
    logic [15:0] e;
    for (int i = 16; i <= 45; i++) put(8'(i), 8'((i * 37 + 5) & 255));
    e = exp_sum();
    put(8'h2E, e[15:8]); put(8'h2F, e[7:0]);
    run_scan(n);
    chk("R9 done latency", n, 31);
    chk("R7 sum", sum, e);
    chk("R8 match", ok, 1);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 idle after", busy, 0);
  endtask

  task automatic t_sum_excl();
    int n;
    put(8'h0F, 8'hEE); put(8'h30, 8'hDD); put(8'h31, 8'hCC);
    run_scan(n);
    chk("R7 excluded bytes", sum, exp_sum());
    chk("R7 still match", ok, 1);
  endtask

  task automatic t_sum_bad();
    int n;
    logic [15:0] e;
    e = exp_sum();
    put(8'h2E, e[7:0]); put(8'h2F, e[15:8]);
    run_scan(n);
    chk("R8 swapped order", ok, exp_ok());
    put(8'h2E, e[15:8]); put(8'h2F, e[7:0] ^ 8'h01);
    run_scan(n);
    chk("R8 low byte off", ok, 0);
  endtask

  task automatic t_busy_start();
    int n;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 5) start = 1'b1;
      if (n == 6) start = 1'b0;
    end
    start = 1'b0;
    chk("R9 restart ignored", n, 31);
    repeat (3) @(negedge clk);
    chk("R9 no second scan", busy, 0);
  endtask

  task automatic t_concurrent();
    int n;
    set_idx(8'h2A);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    dat_we = 1'b1; dat_wd = 8'h9B;
    @(negedge clk); dat_we = 1'b0;
    model[42] = 8'h9B;
    n = 0;
    while (!done && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk("R10 write during scan", sum, exp_sum());
    chk("R10 match flag", ok, exp_ok());
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_ram();
    t_rtc();
    t_rtc_ro();
    t_alias();
    t_sum_good();
    t_sum_excl();
    t_sum_bad();
    t_busy_start();
    t_concurrent();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule